// File: doc/BRIEF.md
# Key-on Wakeup Source Controller

This block decides which pins may wake a low-power microcontroller out of power-down. Eight port pins, handled in four pairs, and one external interrupt pin are watched. Three 4-bit configuration words, reached through a small register bus, set for each source whether it is armed, whether it wakes on a transition or on a steady level, and which polarity counts as active.

Each pin passes through a two-stage synchronizer before any decision is made. Sources set for transitions hold their request once seen, until power-down is left. Sources set for levels follow the pin. The single wakeup output is the OR of all armed sources, and it is only driven high while the power-down indication is asserted. The configuration words are cleared by reset and are not touched by power-down.

Top module: `kwake_ctrl`

## Requirements
- R1: After reset all three configuration words read 0000 and `wake_o` is 0.
- R2: Select values 0, 1 and 2 address configuration words that store all four written bits and return them on read. Bits 3:2 of word 2 have no function but are still stored. Select 3 reads 0000 and ignores writes.
- R3: `wake_o` is 0 whenever `pd_i` is 0, in the same cycle.
- R4: Word 0 bit 0 arms port A pins 0/1 and bit 1 arms port A pins 2/3. An armed pair wakes while either of its pins is low.
- R5: Word 0 bit 2 arms port B pins 0/1 and bit 3 arms port B pins 2/3. Word 1 bit 0 (pins 0/1) and bit 2 (pins 2/3) choose polarity: 0 means falling edge or low level, 1 means rising edge or high level. Word 1 bit 1 (pins 0/1) and bit 3 (pins 2/3) choose the mode: 0 means edge, 1 means level.
- R6: Word 2 bit 0 arms the interrupt pin. Word 2 bit 1 chooses its mode: 0 means level, 1 means edge. The pin is active high, so it wakes on a rising edge or on a high level.
- R7: A pair or pin that is not armed never causes a wakeup, whatever its mode and polarity bits hold.
- R8: A request in edge mode stays asserted after the pin returns, until `pd_i` falls. A request in level mode drops when the pin leaves its active level. Leaving power-down clears any held request.
- R9: Arming a source while its pin already sits at its active level causes no edge wakeup.
- R10: A level wakeup appears at `wake_o` two clock edges after the pin changes. An edge wakeup appears three edges after the change.
- R11: The configuration words keep their contents through a power-down period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 2 | Configuration word select |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data of the selected word |
| port_a_i | input | 4 | Port A pins (two pairs, low-level wake) |
| port_b_i | input | 4 | Port B pins (two configurable pairs) |
| irq_i | input | 1 | External interrupt pin |
| pd_i | input | 1 | Power-down indication |
| wake_o | output | 1 | Wakeup request |

## Verification
A wrong stored bit shows on the very next read of its word. It also shows as a source that wakes or stays silent against its setting, two or three edges after a pin change. A stuck edge latch shows as `wake_o` staying high after the pin returns, or as a request that survives a power-down exit and is seen on re-entry. A bad synchronizer or edge history shows as a wakeup one edge early or late, or as a false wakeup when a source is armed on an already-active pin.

// File: rtl/kwake_pkg.sv
package kwake_pkg;

    localparam int DW        = 4;
    localparam int NREG      = 3;
    localparam int SELW      = 2;
    localparam int NPAIR     = 4;
    localparam int PAIR_PINS = 2;
    localparam int NPINS     = NPAIR * PAIR_PINS + 1;
    localparam int NSRC      = NPAIR + 1;

    typedef enum logic [SELW-1:0] {
        SEL_ARM   = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_IRQ   = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic armed;
        logic by_level;
        logic act_high;
    } src_cfg_t;

    // Pairs 0/1 carry no mode bits: fixed low-level wake.
    // Pairs 2/3 take polarity from bit 2k and mode from bit 2k+1 of the mode word.
    function automatic src_cfg_t pair_cfg(input logic [DW-1:0] arm_w,
                                          input logic [DW-1:0] mode_w,
                                          input int idx);
        src_cfg_t c;
        c.armed = arm_w[idx];
        if (idx < 2) begin
            c.by_level = 1'b1;
            c.act_high = 1'b0;
        end else begin
            c.act_high = mode_w[2*(idx-2)];
            c.by_level = mode_w[2*(idx-2)+1];
        end
        return c;
    endfunction

    // Interrupt pin: mode bit reversed (1 = edge).
    function automatic src_cfg_t irq_cfg(input logic [DW-1:0] irq_w,
                                         input logic act_high);
        src_cfg_t c;
        c.armed    = irq_w[0];
        c.by_level = ~irq_w[1];
        c.act_high = act_high;
        return c;
    endfunction

endpackage

// File: rtl/kwake_regs.sv
module kwake_regs
    import kwake_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [SELW-1:0] sel_i,
    input  logic            we_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic [DW-1:0]   arm_o,
    output logic [DW-1:0]   mode_o,
    output logic [DW-1:0]   irq_o
);

    logic [DW-1:0] bank_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        always_ff @(posedge clk_i) begin
            if (rst_i)
                bank_q[g] <= '0;
            else if (we_i && (sel_i == SELW'(g)))
                bank_q[g] <= wdata_i;
        end

        AST_WORD_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
            !(we_i && (sel_i == SELW'(g))) |=> $stable(bank_q[g])); // R11
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREG; i++)
            if (sel_i == SELW'(i))
                rdata_o = bank_q[i];
    end

    assign arm_o  = bank_q[SEL_ARM];
    assign mode_o = bank_q[SEL_MODE];
    assign irq_o  = bank_q[SEL_IRQ];

    AST_SPARE_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == SEL_SPARE) |-> (rdata_o == '0)); // R2

endmodule

// File: rtl/kwake_sync.sv
module kwake_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i)
                stage_q[s] <= '0;
            else if (s == 0)
                stage_q[s] <= d_i;
            else
                stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/kwake_src.sv
module kwake_src
    import kwake_pkg::*;
#(
    parameter int PINS = 2
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            pd_i,
    input  src_cfg_t        cfg_i,
    input  logic [PINS-1:0] pins_i,
    output logic            hit_o
);

    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] at_level;
    logic [PINS-1:0] edge_seen;
    logic            held_q;
    logic            keep;

    // History follows the sample every cycle, so arming never sees a stale value.
    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= pins_i;
    end

    assign at_level  = cfg_i.act_high ? pins_i : ~pins_i;
    assign edge_seen = cfg_i.act_high ? (pins_i & ~prev_q) : (~pins_i & prev_q);
    assign keep      = pd_i && cfg_i.armed && !cfg_i.by_level;

    always_ff @(posedge clk_i) begin
        if (rst_i) held_q <= 1'b0;
        else       held_q <= keep && (held_q || (|edge_seen));
    end

    assign hit_o = cfg_i.armed && (cfg_i.by_level ? (|at_level) : held_q);

    AST_UNARMED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !cfg_i.armed |-> !hit_o); // R7

    AST_EDGE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (held_q && keep) |=> held_q); // R8

endmodule

// File: rtl/kwake_ctrl.sv
module kwake_ctrl
    import kwake_pkg::*;
#(
    parameter bit IRQ_ACT_HIGH = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic             we_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    input  logic [3:0]       port_a_i,
    input  logic [3:0]       port_b_i,
    input  logic             irq_i,
    input  logic             pd_i,
    output logic             wake_o
);

    logic [DW-1:0]    arm_w, mode_w, irq_w;
    logic [NPINS-1:0] raw_pins, sync_pins;
    logic [NSRC-1:0]  hits;

    kwake_regs u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .sel_i   (sel_i),
        .we_i    (we_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .arm_o   (arm_w),
        .mode_o  (mode_w),
        .irq_o   (irq_w)
    );

    // Layout: [3:0] port A, [7:4] port B, [8] interrupt pin.
    assign raw_pins = {irq_i, port_b_i, port_a_i};

    kwake_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_pins),
        .q_o   (sync_pins)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        kwake_src #(.PINS(PAIR_PINS)) u_src (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .pd_i   (pd_i),
            .cfg_i  (pair_cfg(arm_w, mode_w, g)),
            .pins_i (sync_pins[PAIR_PINS*g +: PAIR_PINS]),
            .hit_o  (hits[g])
        );
    end

    kwake_src #(.PINS(1)) u_irq_src (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pd_i   (pd_i),
        .cfg_i  (irq_cfg(irq_w, IRQ_ACT_HIGH)),
        .pins_i (sync_pins[NPINS-1 +: 1]),
        .hit_o  (hits[NPAIR])
    );

    assign wake_o = pd_i && (|hits);

    AST_AWAKE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !pd_i |-> !wake_o); // R3

    AST_NO_SOURCE_NO_WAKE: assert property (@(posedge clk_i) disable iff (rst_i)
        (arm_w == '0 && irq_w[0] == 1'b0) |-> !wake_o); // R7

endmodule

// File: tb/kwake_ctrl_tb.sv
`timescale 1ns/1ps
module kwake_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = '0;
    logic       we = 1'b0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic [3:0] pa = 4'hF;
    logic [3:0] pb = 4'h0;
    logic       irq = 1'b0;
    logic       pd = 1'b0;
    logic       wake;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    kwake_ctrl dut_i (
        .clk_i (clk), .rst_i (rst), .sel_i (sel), .we_i (we),
        .wdata_i (wdata), .rdata_o (rdata), .port_a_i (pa),
        .port_b_i (pb), .irq_i (irq), .pd_i (pd), .wake_o (wake)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [3:0] v);
        sel = s; wdata = v; we = 1'b1;
        tick(1);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] s, input logic [3:0] exp);
        sel = s; #0.5;
        chk(req, rdata, exp);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        for (int s = 0; s < 4; s++) rd_chk("R1", 2'(s), 4'h0);
        chk("R1 wake", {3'b0, wake}, 4'h0);

        // R2 register sweep
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 16; v++) begin
                wr(2'(s), 4'(v));
                rd_chk("R2", 2'(s), (s == 3) ? 4'h0 : 4'(v));
            end
            wr(2'(s), 4'h0);
        end

        // R4 port A pairs, low-level wake
        for (int en = 0; en < 4; en++) begin
            pd = 1'b0; pa = 4'hF;
            wr(0, 4'(en));
            pd = 1'b1; tick(3);
            for (int idx = 0; idx < 4; idx++) begin
                pa = ~(4'b1 << idx);
                tick(2);
                chk("R4 wake", {3'b0, wake}, {3'b0, 1'((en >> (idx / 2)) & 1)});
                pa = 4'hF;
                tick(2);
                chk("R4 release", {3'b0, wake}, 4'h0);
            end
        end
        pd = 1'b0; wr(0, 4'h0);

        // R5 R7 R8 R10 R3 port B pairs, all modes
        for (int q = 0; q < 2; q++)
          for (int lvl = 0; lvl < 2; lvl++)
            for (int pol = 0; pol < 2; pol++)
              for (int en = 0; en < 2; en++)
                for (int k = 0; k < 2; k++) begin
                    logic [3:0] idle;
                    idle = pol ? 4'h0 : 4'hF;
                    pd = 1'b0; pb = idle; tick(4);
                    wr(1, 4'(((lvl << 1) | pol) << (2 * q)));
                    wr(0, 4'(en << (2 + q)));
                    pd = 1'b1; tick(3);
                    chk("R5 idle", {3'b0, wake}, 4'h0);
                    pb = idle ^ (4'b1 << (2 * q + k));
                    tick(2);
                    chk("R10 level latency", {3'b0, wake}, {3'b0, 1'(en & lvl)});
                    tick(1);
                    chk("R5 R7 active", {3'b0, wake}, {3'b0, 1'(en)});
                    pb = idle;
                    tick(3);
                    chk("R8 after release", {3'b0, wake}, {3'b0, 1'(en & ~lvl)});
                    pd = 1'b0; #0.5;
                    chk("R3 pd low", {3'b0, wake}, 4'h0);
                    tick(2);
                    pd = 1'b1; #0.5;
                    chk("R8 cleared", {3'b0, wake}, 4'h0);
                end
        pd = 1'b0; pb = 4'h0; wr(0, 4'h0); wr(1, 4'h0);

        // R6 interrupt pin
        for (int mb = 0; mb < 2; mb++)
            for (int en = 0; en < 2; en++) begin
                pd = 1'b0; irq = 1'b0; tick(4);
                wr(2, 4'(4'b1100 | (mb << 1) | en));
                pd = 1'b1; tick(3);
                chk("R6 idle", {3'b0, wake}, 4'h0);
                irq = 1'b1; tick(2);
                chk("R6 level", {3'b0, wake}, {3'b0, 1'(en & ~mb)});
                tick(1);
                chk("R6 active", {3'b0, wake}, {3'b0, 1'(en)});
                irq = 1'b0; tick(3);
                chk("R6 release", {3'b0, wake}, {3'b0, 1'(en & mb)});
                pd = 1'b0; tick(1);
            end
        wr(2, 4'h0);

        // R9 arming on an already-active pin
        pd = 1'b0; pb = 4'h1; wr(1, 4'b0001); tick(4);
        pd = 1'b1; tick(1);
        wr(0, 4'b0100);
        tick(4);
        chk("R9 no false edge", {3'b0, wake}, 4'h0);
        pb = 4'h0; tick(3);
        pb = 4'h1; tick(3);
        chk("R9 real edge", {3'b0, wake}, 4'h1);
        pd = 1'b0; pb = 4'h0;

        // R11 retention across power-down
        wr(0, 4'h5); wr(1, 4'hA); wr(2, 4'hC);
        pd = 1'b1; tick(10);
        pd = 1'b0; tick(2);
        rd_chk("R11", 0, 4'h5);
        rd_chk("R11", 1, 4'hA);
        rd_chk("R11", 2, 4'hC);

        finish_run();
    end

endmodule